// File: doc/BRIEF.md
# Data Address Translation and Permission Checker

This block is the front end of data-side address translation. Each request carries a virtual address, an access size, a load/store flag, three request flags (physical, alternate-mode, page-table fetch), the low bit of the program counter and the current and alternate privilege modes. The block either returns a physical address with an uncacheable flag, or a fault code with a six-bit memory-management status word. It runs the faults in a fixed order: alignment, bad address, superpage kernel-only, TLB miss, per-mode permission, then fault-on-access. A machine check and the uncacheable decode are applied last, to any result that is still clean.

Addresses that need a page-table mapping are handed to an external TLB as a page number and an address-space number. The TLB answers with hit, page frame, per-mode read and write enables, and fault-on-read and fault-on-write bits. Six 32-bit counters record read and write hits, misses and violations for those looked-up accesses.

Control is a three-state machine. IDLE accepts a request (`req_ready` high). IDLE goes to RESP when the result needs no lookup, and to LOOKUP otherwise. LOOKUP drives `tlb_req` and stays there until `tlb_rsp_valid`, then goes to RESP. RESP shows `rsp_valid` for one cycle and returns to IDLE.

Top module: `dtx_xlate_top`

## Requirements
- R1: When `vaddr & (size-1)` is nonzero, the fault is ALIGN (code 1) before any other check, even for physical requests. The status holds only the write bit (status bit 0) for stores, and no lookup is made.
- R2: A request with the physical flag that is aligned needs no lookup and returns paddr = vaddr, subject to R11 and R12.
- R3: A non-physical address whose bits 63:47 are not all equal gets fault PAGE (code 2). Its status is bad-address (bit 5) plus access-violation (bit 1), plus write (bit 0) for stores.
- R4: A canonical address with bits 47:41 = 0x7E is a superpage. When the current-mode input is not kernel (0), it gets fault ACV (code 3) with status access-violation plus write for stores. The privileged-code override does not apply here.
- R5: A kernel superpage maps directly to the address's low 44 bits. If bit 40 is set, bits 43:40 are forced to 1; otherwise the address is cut to 40 bits.
- R6: Any other address gets a lookup. `tlb_vpn` = vaddr[47:13] and `tlb_asn` = request ASN, both held until the response. A miss gives MISS (code 4), or DMISS (code 5) for a page-table fetch, with status miss (bit 4) plus write for stores.
- R7: On a hit with no fault, paddr = ppn*8192 + vaddr[12:0].
- R8: Modes are kernel=0, executive=1, supervisor=2, user=3. When the program-counter low bit is 1, the effective mode is kernel, or the alternate mode if the alternate-mode flag is set. Otherwise it is the current mode. Enable bit `[mode]` is used.
- R9: For a store with the write enable clear, the fault is PAGE with write plus access-violation, plus fault-on-write (bit 3) when that entry bit is set. For a store that is enabled but has fault-on-write set, the fault is PAGE with write plus fault-on-write.
- R10: For a load with the read enable clear, the fault is ACV with access-violation, plus fault-on-read (bit 2) when that entry bit is set. For a load that is enabled but has fault-on-read set, the fault is PAGE with fault-on-read.
- R11: A clean result with any address bit at 44 or above gets fault MCHK (code 6), status 0, paddr 0 and uncacheable 0.
- R12: A clean result with bit 43 set returns uncacheable = 1 with bits 42:35 cleared.
- R13: Each TLB response adds one to exactly one counter: for a load or a store, the hit, miss or violation counter. A hit means no TLB or permission fault. Requests with no lookup change no counter.
- R14: `req_ready` is high only in IDLE. A result that needs no lookup shows `rsp_valid` one cycle after acceptance; a looked-up result shows it one cycle after `tlb_rsp_valid`. `rsp_valid` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 64 | Virtual address |
| req_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| req_write | input | 1 | 1 = store |
| req_phys | input | 1 | Bypass translation |
| req_alt | input | 1 | Use alternate mode in privileged code |
| req_ptefetch | input | 1 | Request is a page-table fetch |
| req_pc_tag | input | 1 | Program-counter low bit (1 = privileged code) |
| req_cur_mode | input | 2 | Current mode |
| req_alt_mode | input | 2 | Alternate mode |
| req_asn | input | 8 | Address-space number |
| tlb_req | output | 1 | Lookup in progress |
| tlb_vpn | output | 35 | Virtual page number |
| tlb_asn | output | 8 | Address-space number for the lookup |
| tlb_rsp_valid | input | 1 | TLB response present |
| tlb_hit | input | 1 | Entry found |
| tlb_ppn | input | 32 | Page frame number |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fault_rd | input | 1 | Fault-on-read |
| tlb_fault_wr | input | 1 | Fault-on-write |
| rsp_valid | output | 1 | Result present |
| rsp_fault | output | 3 | Fault code (0 none) |
| rsp_status | output | 6 | Status word |
| rsp_paddr | output | 44 | Physical address |
| rsp_uncache | output | 1 | Access is uncacheable |
| cnt_rd_hit | output | 32 | Load hits |
| cnt_rd_miss | output | 32 | Load misses |
| cnt_rd_viol | output | 32 | Load violations |
| cnt_wr_hit | output | 32 | Store hits |
| cnt_wr_miss | output | 32 | Store misses |
| cnt_wr_viol | output | 32 | Store violations |

## Verification
The assertions assume that the TLB raises `tlb_rsp_valid` only while `tlb_req` is high, and that requests use sizes that are powers of two no larger than 8. The bench acts as the TLB and meets both conditions: it answers only after it has seen `tlb_req`, with a delay of zero to three cycles, and it draws sizes from {1, 2, 4, 8}. The stimulus covers each fault class on purpose. Random requests are sorted into misaligned, physical, non-canonical, superpage and mapped classes, so that every step of the priority chain is reached.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
    localparam int NMODE = 4;
    localparam int ST_W  = 6;
    localparam int ST_WR    = 0;
    localparam int ST_ACV   = 1;
    localparam int ST_FRD   = 2;
    localparam int ST_FWR   = 3;
    localparam int ST_MISS  = 4;
    localparam int ST_BADVA = 5;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_ALIGN = 3'd1,
        FLT_PAGE  = 3'd2,
        FLT_ACV   = 3'd3,
        FLT_MISS  = 3'd4,
        FLT_DMISS = 3'd5,
        FLT_MCHK  = 3'd6
    } fault_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LOOKUP = 2'd1,
        S_RESP   = 2'd2
    } state_e;

    localparam logic [1:0] MODE_KERNEL = 2'd0;
endpackage

// File: rtl/dtx_precheck.sv
module dtx_precheck
    import dtx_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int VA_IMPL   = 48,
    parameter int PA_W      = 44,
    parameter int SP_HI     = 47,
    parameter int SP_LO     = 41,
    parameter logic [SP_HI-SP_LO:0] SP_TAG = 'h7E,
    parameter int SP_EXT_BIT = 40
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic [3:0]      size,
    input  logic            is_write,
    input  logic            phys,
    input  logic [1:0]      cur_mode,
    output logic            need_lookup,
    output fault_e          fault,
    output logic [ST_W-1:0] status,
    output logic [VA_W-1:0] raw
);
    localparam logic [VA_W-1:0] PA_MASK  = {VA_W{1'b1}} >> (VA_W - PA_W);
    localparam logic [VA_W-1:0] LOW_MASK = {VA_W{1'b1}} >> (VA_W - SP_EXT_BIT);
    localparam logic [VA_W-1:0] HI_FILL  = PA_MASK & ~LOW_MASK;

    logic                     misaligned;
    logic                     canonical;
    logic                     superpage;
    logic [VA_W-VA_IMPL:0]    upper;
    logic [VA_W-1:0]          sp_base;
    logic [VA_W-1:0]          sp_raw;

    assign misaligned = |(vaddr[3:0] & (size - 4'd1));
    assign upper      = vaddr[VA_W-1:VA_IMPL-1];
    assign canonical  = (&upper) | ~(|upper);
    assign superpage  = (vaddr[SP_HI:SP_LO] == SP_TAG);
    assign sp_base    = vaddr & PA_MASK;
    assign sp_raw     = sp_base[SP_EXT_BIT] ? (sp_base | HI_FILL) : (sp_base & LOW_MASK);

    always_comb begin
        need_lookup = 1'b0;
        fault       = FLT_NONE;
        status      = '0;
        raw         = vaddr;
        if (misaligned) begin
            fault          = FLT_ALIGN;
            status[ST_WR]  = is_write;
        end else if (phys) begin
            raw = vaddr;
        end else if (!canonical) begin
            fault            = FLT_PAGE;
            status[ST_WR]    = is_write;
            status[ST_ACV]   = 1'b1;
            status[ST_BADVA] = 1'b1;
        end else if (superpage) begin
            if (cur_mode != MODE_KERNEL) begin
                fault          = FLT_ACV;
                status[ST_WR]  = is_write;
                status[ST_ACV] = 1'b1;
            end else begin
                raw = sp_raw;
            end
        end else begin
            need_lookup = 1'b1;
        end
    end
endmodule

// File: rtl/dtx_permit.sv
module dtx_permit
    import dtx_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int PAGE_SHIFT = 13,
    parameter int PPN_W      = 32
) (
    input  logic                  is_write,
    input  logic                  ptefetch,
    input  logic [1:0]            mode,
    input  logic [PAGE_SHIFT-1:0] offset,
    input  logic                  hit,
    input  logic [PPN_W-1:0]      ppn,
    input  logic [NMODE-1:0]      rd_en,
    input  logic [NMODE-1:0]      wr_en,
    input  logic                  f_rd,
    input  logic                  f_wr,
    output fault_e                fault,
    output logic [ST_W-1:0]       status,
    output logic [VA_W-1:0]       raw,
    output logic                  ev_miss,
    output logic                  ev_viol
);
    assign raw = (VA_W'(ppn) << PAGE_SHIFT) + VA_W'(offset);

    always_comb begin
        fault   = FLT_NONE;
        status  = '0;
        ev_miss = 1'b0;
        ev_viol = 1'b0;
        if (!hit) begin
            ev_miss         = 1'b1;
            fault           = ptefetch ? FLT_DMISS : FLT_MISS;
            status[ST_WR]   = is_write;
            status[ST_MISS] = 1'b1;
        end else if (is_write) begin
            if (!wr_en[mode]) begin
                ev_viol        = 1'b1;
                fault          = FLT_PAGE;
                status[ST_WR]  = 1'b1;
                status[ST_ACV] = 1'b1;
                status[ST_FWR] = f_wr;
            end else if (f_wr) begin
                ev_viol        = 1'b1;
                fault          = FLT_PAGE;
                status[ST_WR]  = 1'b1;
                status[ST_FWR] = 1'b1;
            end
        end else begin
            if (!rd_en[mode]) begin
                ev_viol        = 1'b1;
                fault          = FLT_ACV;
                status[ST_ACV] = 1'b1;
                status[ST_FRD] = f_rd;
            end else if (f_rd) begin
                ev_viol        = 1'b1;
                fault          = FLT_PAGE;
                status[ST_FRD] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dtx_finish.sv
module dtx_finish
    import dtx_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PA_W      = 44,
    parameter int UC_BIT    = 43,
    parameter int UC_CLR_HI = 42,
    parameter int UC_CLR_LO = 35
) (
    input  fault_e           fault_in,
    input  logic [ST_W-1:0]  status_in,
    input  logic [VA_W-1:0]  raw,
    output fault_e           fault,
    output logic [ST_W-1:0]  status,
    output logic [PA_W-1:0]  paddr,
    output logic             uncache
);
    localparam logic [VA_W-1:0] PA_MASK = {VA_W{1'b1}} >> (VA_W - PA_W);
    localparam logic [VA_W-1:0] UC_CLR  = ({VA_W{1'b1}} >> (VA_W - (UC_CLR_HI + 1)))
                                        & ~({VA_W{1'b1}} >> (VA_W - UC_CLR_LO));

    always_comb begin
        fault   = fault_in;
        status  = status_in;
        paddr   = '0;
        uncache = 1'b0;
        if (fault_in == FLT_NONE) begin
            if (|(raw & ~PA_MASK)) begin
                fault  = FLT_MCHK;
                status = '0;
            end else if (raw[UC_BIT]) begin
                uncache = 1'b1;
                paddr   = PA_W'(raw & ~UC_CLR);
            end else begin
                paddr = PA_W'(raw);
            end
        end
    end
endmodule

// File: rtl/dtx_counters.sv
module dtx_counters #(
    parameter int N     = 6,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     inc,
    output logic [CNT_W-1:0] cnt [N]
);
    for (genvar g = 0; g < N; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n) cnt[g] <= '0;
            else if (inc[g]) cnt[g] <= cnt[g] + 1'b1;
        end

        a_r13_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !inc[g] |=> $stable(cnt[g]));
    end

    a_r13_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inc));
endmodule

// File: rtl/dtx_xlate_top.sv
module dtx_xlate_top
    import dtx_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int VA_IMPL    = 48,
    parameter int PA_W       = 44,
    parameter int PAGE_SHIFT = 13,
    parameter int PPN_W      = 32,
    parameter int ASN_W      = 8,
    parameter int CNT_W      = 32,
    parameter int UC_BIT     = 43,
    parameter int UC_CLR_HI  = 42,
    parameter int UC_CLR_LO  = 35
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [VA_W-1:0]               req_vaddr,
    input  logic [3:0]                    req_size,
    input  logic                          req_write,
    input  logic                          req_phys,
    input  logic                          req_alt,
    input  logic                          req_ptefetch,
    input  logic                          req_pc_tag,
    input  logic [1:0]                    req_cur_mode,
    input  logic [1:0]                    req_alt_mode,
    input  logic [ASN_W-1:0]              req_asn,
    output logic                          tlb_req,
    output logic [VA_IMPL-PAGE_SHIFT-1:0] tlb_vpn,
    output logic [ASN_W-1:0]              tlb_asn,
    input  logic                          tlb_rsp_valid,
    input  logic                          tlb_hit,
    input  logic [PPN_W-1:0]              tlb_ppn,
    input  logic [3:0]                    tlb_rd_en,
    input  logic [3:0]                    tlb_wr_en,
    input  logic                          tlb_fault_rd,
    input  logic                          tlb_fault_wr,
    output logic                          rsp_valid,
    output logic [2:0]                    rsp_fault,
    output logic [5:0]                    rsp_status,
    output logic [PA_W-1:0]               rsp_paddr,
    output logic                          rsp_uncache,
    output logic [CNT_W-1:0]              cnt_rd_hit,
    output logic [CNT_W-1:0]              cnt_rd_miss,
    output logic [CNT_W-1:0]              cnt_rd_viol,
    output logic [CNT_W-1:0]              cnt_wr_hit,
    output logic [CNT_W-1:0]              cnt_wr_miss,
    output logic [CNT_W-1:0]              cnt_wr_viol
);
    localparam int NCNT = 6;

    state_e st, st_nx;

    logic [VA_IMPL-1:0] cap_va;
    logic               cap_wr, cap_pte;
    logic [1:0]         cap_mode;
    logic [ASN_W-1:0]   cap_asn;
    logic [1:0]         eff_mode;
    logic               accept, lk_done, load_res;

    logic            pre_lookup;
    fault_e          pre_fault, pm_fault, mux_fault, fin_fault, rsp_fault_q;
    logic [ST_W-1:0] pre_status, pm_status, mux_status, fin_status;
    logic [VA_W-1:0] pre_raw, pm_raw, mux_raw;
    logic            pm_miss, pm_viol;
    logic [PA_W-1:0] fin_paddr;
    logic            fin_uc;
    logic [NCNT-1:0]  cnt_inc;
    logic [CNT_W-1:0] cnt_q [NCNT];

    assign accept  = req_valid && (st == S_IDLE);
    assign lk_done = (st == S_LOOKUP) && tlb_rsp_valid;

    // privileged code runs in kernel mode unless it asks for the alternate mode
    assign eff_mode = req_pc_tag ? (req_alt ? req_alt_mode : MODE_KERNEL) : req_cur_mode;

    dtx_precheck #(.VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_W(PA_W)) u_pre (
        .vaddr(req_vaddr), .size(req_size), .is_write(req_write), .phys(req_phys),
        .cur_mode(req_cur_mode), .need_lookup(pre_lookup), .fault(pre_fault),
        .status(pre_status), .raw(pre_raw)
    );

    dtx_permit #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .PPN_W(PPN_W)) u_perm (
        .is_write(cap_wr), .ptefetch(cap_pte), .mode(cap_mode),
        .offset(cap_va[PAGE_SHIFT-1:0]), .hit(tlb_hit), .ppn(tlb_ppn),
        .rd_en(tlb_rd_en), .wr_en(tlb_wr_en), .f_rd(tlb_fault_rd), .f_wr(tlb_fault_wr),
        .fault(pm_fault), .status(pm_status), .raw(pm_raw),
        .ev_miss(pm_miss), .ev_viol(pm_viol)
    );

    assign mux_fault  = (st == S_LOOKUP) ? pm_fault  : pre_fault;
    assign mux_status = (st == S_LOOKUP) ? pm_status : pre_status;
    assign mux_raw    = (st == S_LOOKUP) ? pm_raw    : pre_raw;

    dtx_finish #(.VA_W(VA_W), .PA_W(PA_W), .UC_BIT(UC_BIT),
                 .UC_CLR_HI(UC_CLR_HI), .UC_CLR_LO(UC_CLR_LO)) u_fin (
        .fault_in(mux_fault), .status_in(mux_status), .raw(mux_raw),
        .fault(fin_fault), .status(fin_status), .paddr(fin_paddr), .uncache(fin_uc)
    );

    // counter slots: 0 rd hit, 1 rd miss, 2 rd viol, 3 wr hit, 4 wr miss, 5 wr viol
    assign cnt_inc[0] = lk_done && !cap_wr && !pm_miss && !pm_viol;
    assign cnt_inc[1] = lk_done && !cap_wr && pm_miss;
    assign cnt_inc[2] = lk_done && !cap_wr && pm_viol;
    assign cnt_inc[3] = lk_done &&  cap_wr && !pm_miss && !pm_viol;
    assign cnt_inc[4] = lk_done &&  cap_wr && pm_miss;
    assign cnt_inc[5] = lk_done &&  cap_wr && pm_viol;

    dtx_counters #(.N(NCNT), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .cnt(cnt_q)
    );

    assign cnt_rd_hit  = cnt_q[0];
    assign cnt_rd_miss = cnt_q[1];
    assign cnt_rd_viol = cnt_q[2];
    assign cnt_wr_hit  = cnt_q[3];
    assign cnt_wr_miss = cnt_q[4];
    assign cnt_wr_viol = cnt_q[5];

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:   if (accept) st_nx = pre_lookup ? S_LOOKUP : S_RESP;
            S_LOOKUP: if (tlb_rsp_valid) st_nx = S_RESP;
            S_RESP:   st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    assign load_res = (accept && !pre_lookup) || lk_done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_va      <= '0;
            cap_wr      <= 1'b0;
            cap_pte     <= 1'b0;
            cap_mode    <= MODE_KERNEL;
            cap_asn     <= '0;
            rsp_fault_q <= FLT_NONE;
            rsp_status  <= '0;
            rsp_paddr   <= '0;
            rsp_uncache <= 1'b0;
        end else begin
            if (accept) begin
                cap_va   <= req_vaddr[VA_IMPL-1:0];
                cap_wr   <= req_write;
                cap_pte  <= req_ptefetch;
                cap_mode <= eff_mode;
                cap_asn  <= req_asn;
            end
            if (load_res) begin
                rsp_fault_q <= fin_fault;
                rsp_status  <= fin_status;
                rsp_paddr   <= fin_paddr;
                rsp_uncache <= fin_uc;
            end
        end
    end

    assign req_ready = (st == S_IDLE);
    assign tlb_req   = (st == S_LOOKUP);
    assign tlb_vpn   = cap_va[VA_IMPL-1:PAGE_SHIFT];
    assign tlb_asn   = cap_asn;
    assign rsp_valid = (st == S_RESP);
    assign rsp_fault = rsp_fault_q;

    a_r14_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r14_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_req || rsp_valid) |-> !req_ready);
    a_r6_lookup_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_req && !tlb_rsp_valid) |=> tlb_req && $stable(tlb_vpn) && $stable(tlb_asn));
    a_r1_align_wr_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_ALIGN) |-> rsp_status[ST_W-1:1] == '0);
    a_r6_miss_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault == FLT_MISS || rsp_fault == FLT_DMISS)) |-> rsp_status[ST_MISS]);
    a_r11_mchk_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_MCHK) |-> (rsp_status == '0 && !rsp_uncache));
    a_r12_uc_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_uncache) |->
            (rsp_paddr[UC_BIT] && rsp_paddr[UC_CLR_HI:UC_CLR_LO] == '0 && rsp_fault == FLT_NONE));
endmodule

// File: tb/dtx_xlate_top_tb_top.sv
`timescale 1ns/1ps
module dtx_xlate_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_phys = 0, req_alt = 0, req_ptefetch = 0, req_pc_tag = 0;
    logic [63:0] req_vaddr = '0;
    logic [3:0]  req_size = 4'd1;
    logic [1:0]  req_cur_mode = 0, req_alt_mode = 0;
    logic [7:0]  req_asn = 0;
    logic        req_ready, tlb_req, rsp_valid, rsp_uncache;
    logic [34:0] tlb_vpn;
    logic [7:0]  tlb_asn;
    logic        tlb_rsp_valid = 0, tlb_hit = 0, tlb_fault_rd = 0, tlb_fault_wr = 0;
    logic [31:0] tlb_ppn = 0;
    logic [3:0]  tlb_rd_en = 0, tlb_wr_en = 0;
    logic [2:0]  rsp_fault;
    logic [5:0]  rsp_status;
    logic [43:0] rsp_paddr;
    logic [31:0] cnt_rd_hit, cnt_rd_miss, cnt_rd_viol, cnt_wr_hit, cnt_wr_miss, cnt_wr_viol;

    always #2 clk = ~clk;

    dtx_xlate_top dut_i (.*);

    int checks = 0;
    int errors = 0;
    int exp_cnt [6];

    // expected results
    logic        e_lk, e_viol;
    int          e_flt;
    logic [5:0]  e_st;
    logic [63:0] e_pa;
    logic        e_uc;
    string       e_tag;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference of the whole priority chain
    task automatic model(input logic [63:0] va, input int sz, input logic wr, ph, al, pt, pct,
                         input int cm, am, input logic hit, input logic [31:0] ppn,
                         input logic [3:0] ren, wen, input logic frd, fwr);
        logic [63:0] raw;
        int mode;
        e_lk = 0; e_viol = 0; e_flt = 0; e_st = 0; e_pa = 0; e_uc = 0; raw = va;
        if ((va % 64'(sz)) != 0) begin
            e_flt = 1; e_st = wr ? 6'd1 : 6'd0; e_tag = "R1";
        end else if (ph) begin
            e_tag = "R2";
        end else if (!((va >> 47) == 0 || (va >> 47) == 64'h1FFFF)) begin
            e_flt = 2; e_st = 6'd34 | (wr ? 6'd1 : 6'd0); e_tag = "R3";
        end else if (((va >> 41) & 64'h7F) == 64'h7E) begin
            if (cm != 0) begin
                e_flt = 3; e_st = 6'd2 | (wr ? 6'd1 : 6'd0); e_tag = "R4";
            end else begin
                raw = va & 64'hFFF_FFFF_FFFF;
                if (raw[40]) raw = raw | 64'hF00_0000_0000;
                else raw = raw & 64'hFF_FFFF_FFFF;
                e_tag = "R5";
            end
        end else begin
            e_lk = 1;
            if (!hit) begin
                e_flt = pt ? 5 : 4; e_st = 6'd16 | (wr ? 6'd1 : 6'd0); e_tag = "R6";
            end else begin
                mode = pct ? (al ? am : 0) : cm;
                raw = 64'(ppn) * 64'd8192 + (va & 64'h1FFF);
                e_tag = pct ? "R8" : "R7";
                if (wr) begin
                    if (!wen[mode]) begin
                        e_flt = 2; e_st = 6'd3 | (fwr ? 6'd8 : 6'd0); e_viol = 1; e_tag = "R9";
                    end else if (fwr) begin
                        e_flt = 2; e_st = 6'd9; e_viol = 1; e_tag = "R9";
                    end
                end else begin
                    if (!ren[mode]) begin
                        e_flt = 3; e_st = 6'd2 | (frd ? 6'd4 : 6'd0); e_viol = 1; e_tag = "R10";
                    end else if (frd) begin
                        e_flt = 2; e_st = 6'd4; e_viol = 1; e_tag = "R10";
                    end
                end
            end
        end
        if (e_flt == 0) begin
            if ((raw >> 44) != 0) begin
                e_flt = 6; e_st = 0; e_tag = "R11";
            end else if (raw[43]) begin
                e_uc = 1; e_pa = raw & ~(64'hFF << 35); e_tag = "R12";
            end else begin
                e_pa = raw;
            end
        end
    endtask

    task automatic chk_counters();
        chk("R13 rd_hit",  64'(cnt_rd_hit),  64'(exp_cnt[0]));
        chk("R13 rd_miss", 64'(cnt_rd_miss), 64'(exp_cnt[1]));
        chk("R13 rd_viol", 64'(cnt_rd_viol), 64'(exp_cnt[2]));
        chk("R13 wr_hit",  64'(cnt_wr_hit),  64'(exp_cnt[3]));
        chk("R13 wr_miss", 64'(cnt_wr_miss), 64'(exp_cnt[4]));
        chk("R13 wr_viol", 64'(cnt_wr_viol), 64'(exp_cnt[5]));
    endtask

    task automatic do_req(input logic [63:0] va, input int sz, input logic wr, ph, al, pt, pct,
                          input int cm, am, input logic [7:0] asn, input logic hit,
                          input logic [31:0] ppn, input logic [3:0] ren, wen,
                          input logic frd, fwr, input int lat);
        int base;
        model(va, sz, wr, ph, al, pt, pct, cm, am, hit, ppn, ren, wen, frd, fwr);
        @(negedge clk);
        chk("R14 ready", 64'(req_ready), 64'd1);
        req_valid = 1; req_vaddr = va; req_size = 4'(sz); req_write = wr; req_phys = ph;
        req_alt = al; req_ptefetch = pt; req_pc_tag = pct; req_cur_mode = 2'(cm);
        req_alt_mode = 2'(am); req_asn = asn;
        @(negedge clk);
        req_valid = 0;
        if (e_lk) begin
            chk("R6 tlb_req", 64'(tlb_req), 64'd1);
            chk("R6 vpn", 64'(tlb_vpn), 64'(va[47:13]));
            chk("R6 asn", 64'(tlb_asn), 64'(asn));
            for (int i = 0; i < lat; i++) begin
                chk("R14 wait", 64'(rsp_valid), 64'd0);
                chk("R14 busy", 64'(req_ready), 64'd0);
                @(negedge clk);
            end
            tlb_rsp_valid = 1; tlb_hit = hit; tlb_ppn = ppn; tlb_rd_en = ren;
            tlb_wr_en = wen; tlb_fault_rd = frd; tlb_fault_wr = fwr;
            @(negedge clk);
            tlb_rsp_valid = 0; tlb_hit = 0; tlb_ppn = 0; tlb_rd_en = 0;
            tlb_wr_en = 0; tlb_fault_rd = 0; tlb_fault_wr = 0;
            base = wr ? 3 : 0;
            if (!hit) exp_cnt[base + 1]++;
            else if (e_viol) exp_cnt[base + 2]++;
            else exp_cnt[base]++;
        end else begin
            chk({e_tag, " no lookup"}, 64'(tlb_req), 64'd0);
        end
        chk({e_tag, " R14 rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({e_tag, " fault"}, 64'(rsp_fault), 64'(e_flt));
        chk({e_tag, " status"}, 64'(rsp_status), 64'(e_st));
        chk({e_tag, " paddr"}, 64'(rsp_paddr), e_pa);
        chk({e_tag, " uncache"}, 64'(rsp_uncache), 64'(e_uc));
        @(negedge clk);
        chk("R14 pulse", 64'(rsp_valid), 64'd0);
        chk_counters();
    endtask

    function automatic int pick_size();
        case ($urandom % 4)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 8;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R14 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] va;
        int sz, c;
        logic [31:0] ppn;
        for (int i = 0; i < 6; i++) exp_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R14 reset ready", 64'(req_ready), 64'd1);
        chk("R14 reset rsp", 64'(rsp_valid), 64'd0);
        chk("R6 reset tlb_req", 64'(tlb_req), 64'd0);
        chk_counters();

        // R1: misaligned store, and misaligned physical load (alignment wins)
        do_req(64'h1002, 4, 1, 0, 0, 0, 0, 0, 0, 8'h1, 1, 32'h5, 4'hF, 4'hF, 0, 0, 0);
        do_req(64'h1001, 2, 0, 1, 0, 0, 0, 3, 0, 8'h1, 1, 32'h5, 4'hF, 4'hF, 0, 0, 0);
        // R2 physical bypass; R11 physical with high bit
        do_req(64'h123_4567_8000, 8, 0, 1, 0, 0, 0, 3, 0, 8'h2, 0, 0, 0, 0, 0, 0, 0);
        do_req(64'h0004_0000_0000_1000, 8, 1, 1, 0, 0, 0, 0, 0, 8'h2, 0, 0, 0, 0, 0, 0, 0);
        // R3 non-canonical store
        do_req(64'h0001_0000_0000_0000, 8, 1, 0, 0, 0, 0, 0, 0, 8'h3, 0, 0, 0, 0, 0, 0, 0);
        // R4 superpage in user mode, and in privileged code with user register
        do_req(64'hFFFF_FC00_0000_1000, 8, 0, 0, 0, 0, 0, 3, 0, 8'h4, 0, 0, 0, 0, 0, 0, 0);
        do_req(64'hFFFF_FC00_0000_1000, 8, 1, 0, 0, 0, 1, 3, 0, 8'h4, 0, 0, 0, 0, 0, 0, 0);
        // R5 kernel superpage, bit 40 clear and set (set also gives R12)
        do_req(64'hFFFF_FC00_0000_1000, 8, 0, 0, 0, 0, 0, 0, 0, 8'h4, 0, 0, 0, 0, 0, 0, 0);
        do_req(64'hFFFF_FD00_1234_5678, 8, 0, 0, 0, 0, 0, 0, 0, 8'h4, 0, 0, 0, 0, 0, 0, 0);
        // R6 miss load with latency, page-table fetch miss store
        do_req(64'h0000_0012_3456_7000, 4, 0, 0, 0, 0, 0, 3, 0, 8'h55, 0, 0, 0, 0, 0, 0, 2);
        do_req(64'h0000_0012_3456_7000, 4, 1, 0, 0, 1, 0, 3, 0, 8'h56, 0, 0, 0, 0, 0, 0, 1);
        // R7 user hit
        do_req(64'h0000_0000_0040_1ABC, 4, 0, 0, 0, 0, 0, 3, 0, 8'h7, 1, 32'h12345, 4'h8, 4'h0, 0, 0, 3);
        // R8 privileged code: kernel override allows; alt mode user denies
        do_req(64'h0000_0000_0040_1AB0, 8, 0, 0, 0, 0, 1, 3, 3, 8'h8, 1, 32'h777, 4'h1, 4'h0, 0, 0, 0);
        do_req(64'h0000_0000_0040_1AB0, 8, 0, 0, 1, 0, 1, 0, 3, 8'h8, 1, 32'h777, 4'h1, 4'h0, 0, 0, 0);
        // R9 store: enable clear with fault-on-write, enable set with fault-on-write
        do_req(64'h2000, 8, 1, 0, 0, 0, 0, 1, 0, 8'h9, 1, 32'h10, 4'hF, 4'hD, 0, 1, 0);
        do_req(64'h2000, 8, 1, 0, 0, 0, 0, 1, 0, 8'h9, 1, 32'h10, 4'hF, 4'hF, 0, 1, 0);
        // R10 load: enable clear with fault-on-read, enable set with fault-on-read
        do_req(64'h2008, 8, 0, 0, 0, 0, 0, 2, 0, 8'hA, 1, 32'h10, 4'hB, 4'h0, 1, 0, 1);
        do_req(64'h2008, 8, 0, 0, 0, 0, 0, 2, 0, 8'hA, 1, 32'h10, 4'hF, 4'h0, 1, 0, 1);
        // R11 hit beyond implemented range; R12 hit into uncached space
        do_req(64'h3000, 1, 0, 0, 0, 0, 0, 0, 0, 8'hB, 1, 32'h8000_0001, 4'h1, 4'h1, 0, 0, 0);
        do_req(64'h3010, 1, 1, 0, 0, 0, 0, 0, 0, 8'hB, 1, 32'h43FF_FFFF, 4'h1, 4'h1, 0, 0, 0);

        for (int n = 0; n < 400; n++) begin
            c  = $urandom % 8;
            sz = pick_size();
            va = {$urandom, $urandom};
            case (c)
                0: begin
                    if (sz == 1) sz = 4;
                    va[0] = 1'b1;
                end
                1: if ($urandom % 2) va[63:44] = '0;
                2: va[63:47] = 17'h00010;
                3: begin
                    va[63:47] = '1;
                    va[46:41] = 6'h3E;
                end
                default: begin
                    va[63:47] = ($urandom % 2) ? '1 : '0;
                    if (va[47:41] == 7'h7E) va[41] = 1'b0;
                end
            endcase
            if (c != 0) va = va & ~64'(sz - 1);
            ppn = $urandom;
            case ($urandom % 4)
                0: ppn[31:30] = 2'b01;
                1: ppn[31] = 1'b1;
                default: ppn[31:30] = 2'b00;
            endcase
            do_req(va, sz, 1'($urandom), (c == 1), 1'($urandom), 1'($urandom),
                   ($urandom % 3 == 0), int'($urandom % 4), int'($urandom % 4),
                   8'($urandom), ($urandom % 5 != 0), ppn, 4'($urandom), 4'($urandom),
                   ($urandom % 4 == 0), ($urandom % 4 == 0), int'($urandom % 4));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule